// File: doc/BRIEF.md
# Hardware Address Breakpoint Unit

This unit sits beside a processor core and watches its memory access bus. Software programs up to four watch addresses, each with its own region length (one byte, an even-aligned word or a four-aligned doubleword) and its own access class (first byte of an instruction fetch, data writes only, or any data access). When an access on the bus touches a programmed region of the right class, the unit records a sticky hit bit. If that watch is armed, it also raises a one-cycle trap request on the next clock.

Each watch has two enable bits, a per-task one and a system-wide one. A task-switch pulse wipes every per-task enable and keeps the system-wide ones. A debugger can therefore keep permanent watches alive across tasks while per-task watches vanish on the switch. A single-step indication and an emulation-override input also feed the status word. While the override is held, all address comparisons are suppressed.

Top module: `addr_watch_unit`

## Requirements
- R1: After reset the status output, the trap output and every register readback are zero.
- R2: Register port map, selected by `regAddr`: 0 to 3 are the four watch addresses (all 32 bits writable), 4 is control (only bits 31:16 and 9:0 are kept, the others read 0), 5 is status (only bits 15:13 and 3:0 are kept). `regRdData` shows the selected register in the same cycle. A write takes effect on the next clock.
- R3: Each watch n has a 4-bit control field at bits 16+4n upward: the low two bits are the access class and the high two bits are the length. Length 00 (byte) hits only an access that covers the exact watch address. A hit sets status bit n.
- R4: Length 01 (word) hits any access that covers either byte of the 2-byte region that holds the watch address. Watch address bit 0 is ignored.
- R5: Length 11 (doubleword) hits any access that covers a byte of the 4-byte aligned region that holds the watch address. Watch address bits 1:0 are ignored. Access size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes.
- R6: Access class 01 hits data writes only. Class 11 hits data reads and writes. Class 00 hits only an instruction fetch (`busKind` 0) with `busFirst` set, and only when the length is 00. The `busKind` codes are 1 = data read and 2 = data write.
- R7: Length code 10 and class code 10 never produce a hit.
- R8: Control bit 2n is the per-task enable and bit 2n+1 is the system-wide enable of watch n. A hit raises `trapReq` when either bit is set. With both clear, the hit still sets its status bit but no trap is raised.
- R9: `trapReq` is high for exactly the clock after each cycle that has an armed hit. It fires again on every later matching access.
- R10: A `taskSwitch` pulse clears control bits 0, 2, 4, 6 and 8, keeps every other control bit, and sets status bit 15.
- R11: Status bits stay set until software writes the status register. A hit in the same cycle as that write still lands in the new value.
- R12: While `emuOverride` is high, no watch hits, no hit bit sets and no hit trap is raised. Status bit 13 is set.
- R13: A cycle with `singleStep` high sets status bit 14 and raises `trapReq` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register select for write and readback |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Readback of the selected register |
| busValid | input | 1 | Monitored bus carries an access this cycle |
| busAddr | input | 32 | Physical address of the access |
| busSize | input | 2 | Access size code |
| busKind | input | 2 | Access kind code |
| busFirst | input | 1 | Fetch is of an instruction's first byte |
| taskSwitch | input | 1 | Task-switch pulse |
| singleStep | input | 1 | Single-step indication |
| emuOverride | input | 1 | Emulation override, suppresses comparisons |
| trapReq | output | 1 | One-cycle trap request |
| statusOut | output | 32 | Sticky status word |

## Verification
Hit detection is combinational, and each of its effects lands one clock edge after the access is presented: the status bit, the trap pulse and the per-task enable clearing. Register readback is combinational on the state that the previous edge produced. The bench sets the inputs shortly after a rising edge. Its reference model then computes the next state from the old state and those inputs. After the following edge it compares `statusOut`, `trapReq` and `regRdData` against the model. Directed checks of the trap and of single status bits are sampled at that same point, so every expected value belongs to exactly one access.

// File: rtl/watch_pkg.sv
package watch_pkg;
  localparam int REG_W      = 32;
  localparam int NUM_BP     = 4;
  localparam int REG_AW     = 3;
  localparam int FIELD_W    = 4;
  localparam int FIELD_LSB  = 16;
  localparam int CTL_REG    = NUM_BP;
  localparam int STAT_REG   = NUM_BP + 1;
  localparam int EXACT_BIT  = 2 * NUM_BP;
  localparam int EMU_BIT    = 13;
  localparam int STEP_BIT   = 14;
  localparam int TASK_BIT   = 15;

  localparam logic [REG_W-1:0] CTL_MASK  = 32'hFFFF_03FF;
  localparam logic [REG_W-1:0] STAT_MASK = 32'h0000_E00F;
  localparam logic [REG_W-1:0] LOCAL_MASK = 32'h0000_0155;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_READ  = 2'd1,
    KIND_WRITE = 2'd2,
    KIND_NONE  = 2'd3
  } kind_e;

  typedef struct packed {
    logic [NUM_BP-1:0] addrWr;
    logic              ctlWr;
    logic              statWr;
    logic              localClr;
  } strobe_t;
endpackage

// File: rtl/watch_cmp.sv
module watch_cmp
  import watch_pkg::*;
#(
  parameter int AddrW = REG_W
) (
  input  logic [AddrW-1:0] bpAddr,
  input  logic [1:0]       lenCode,
  input  logic [1:0]       typeCode,
  input  logic             busValid,
  input  logic [AddrW-1:0] busAddr,
  input  logic [1:0]       busSize,
  input  logic [1:0]       busKind,
  input  logic             busFirst,
  input  logic             suppress,
  output logic             hit
);
  logic [AddrW-1:0] lowMask;
  logic [AddrW-1:0] regionLo;
  logic [AddrW:0]   regionHi;
  logic [AddrW:0]   accLo;
  logic [AddrW:0]   accHi;
  logic [2:0]       spanM1;
  logic             lenOk;
  logic             typeOk;
  logic             overlap;

  always_comb begin
    case (lenCode)
      2'b01:   lowMask = AddrW'(1);
      2'b11:   lowMask = AddrW'(3);
      default: lowMask = '0;
    endcase
    lenOk = (lenCode != 2'b10);
  end

  always_comb begin
    case (typeCode)
      2'b00:   typeOk = (busKind == KIND_FETCH) && busFirst && (lenCode == 2'b00);
      2'b01:   typeOk = (busKind == KIND_WRITE);
      2'b11:   typeOk = (busKind == KIND_WRITE) || (busKind == KIND_READ);
      default: typeOk = 1'b0;
    endcase
  end

  always_comb begin
    if (busKind == KIND_FETCH) spanM1 = 3'd0;
    else begin
      case (busSize)
        2'd0:    spanM1 = 3'd0;
        2'd1:    spanM1 = 3'd1;
        default: spanM1 = 3'd3;
      endcase
    end
  end

  assign regionLo = bpAddr & ~lowMask;
  assign regionHi = {1'b0, regionLo} + {1'b0, lowMask};
  assign accLo    = {1'b0, busAddr};
  assign accHi    = accLo + {{(AddrW-2){1'b0}}, spanM1};
  assign overlap  = (accLo <= regionHi) && (accHi >= {1'b0, regionLo});
  assign hit      = busValid && !suppress && lenOk && typeOk && overlap;
endmodule

// File: rtl/watch_dp.sv
module watch_dp
  import watch_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic [REG_AW-1:0]   regAddr,
  input  logic [REG_W-1:0]    regWrData,
  input  logic [REG_W-1:0]    statusIn,
  output logic [REG_W-1:0]    regRdData,
  input  logic                busValid,
  input  logic [REG_W-1:0]    busAddr,
  input  logic [1:0]          busSize,
  input  logic [1:0]          busKind,
  input  logic                busFirst,
  input  logic                emuOverride,
  output logic [REG_W-1:0]    ctlQ,
  output logic [NUM_BP-1:0]   hitVec,
  output logic [NUM_BP-1:0]   armVec
);
  logic [REG_W-1:0] addrQ [NUM_BP];
  logic [REG_W-1:0] ctlD;

  always_ff @(posedge clk) begin
    for (int n = 0; n < NUM_BP; n++) begin
      if (!rstN)                addrQ[n] <= '0;
      else if (strb.addrWr[n])  addrQ[n] <= regWrData;
    end
  end

  always_comb begin
    ctlD = ctlQ;
    if (strb.ctlWr)    ctlD = regWrData & CTL_MASK;
    if (strb.localClr) ctlD = ctlD & ~LOCAL_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) ctlQ <= '0;
    else       ctlQ <= ctlD;
  end

  for (genvar n = 0; n < NUM_BP; n++) begin : g_bp
    watch_cmp #(.AddrW(REG_W)) u_cmp (
      .bpAddr   (addrQ[n]),
      .lenCode  (ctlQ[FIELD_LSB + FIELD_W*n + 2 +: 2]),
      .typeCode (ctlQ[FIELD_LSB + FIELD_W*n +: 2]),
      .busValid (busValid),
      .busAddr  (busAddr),
      .busSize  (busSize),
      .busKind  (busKind),
      .busFirst (busFirst),
      .suppress (emuOverride),
      .hit      (hitVec[n])
    );
    assign armVec[n] = ctlQ[2*n] | ctlQ[2*n+1];
  end

  always_comb begin
    if (int'(regAddr) < NUM_BP)       regRdData = addrQ[regAddr[1:0]];
    else if (int'(regAddr) == CTL_REG)  regRdData = ctlQ;
    else if (int'(regAddr) == STAT_REG) regRdData = statusIn;
    else                                regRdData = '0;
  end
endmodule

// File: rtl/watch_ctrl.sv
module watch_ctrl
  import watch_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic [REG_W-1:0]   regWrData,
  input  logic               taskSwitch,
  input  logic               singleStep,
  input  logic               emuOverride,
  input  logic [NUM_BP-1:0]  hitVec,
  input  logic [NUM_BP-1:0]  armVec,
  output strobe_t            strb,
  output logic [REG_W-1:0]   statusQ,
  output logic               trapQ
);
  logic [REG_W-1:0] statusD;

  always_comb begin
    for (int n = 0; n < NUM_BP; n++)
      strb.addrWr[n] = regWrEn && (int'(regAddr) == n);
    strb.ctlWr    = regWrEn && (int'(regAddr) == CTL_REG);
    strb.statWr   = regWrEn && (int'(regAddr) == STAT_REG);
    strb.localClr = taskSwitch;
  end

  always_comb begin
    statusD = statusQ;
    if (strb.statWr) statusD = regWrData & STAT_MASK;
    statusD[NUM_BP-1:0] = statusD[NUM_BP-1:0] | hitVec;
    if (emuOverride) statusD[EMU_BIT]  = 1'b1;
    if (singleStep)  statusD[STEP_BIT] = 1'b1;
    if (taskSwitch)  statusD[TASK_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      trapQ   <= 1'b0;
    end else begin
      statusQ <= statusD;
      trapQ   <= (|(hitVec & armVec)) | singleStep;
    end
  end
endmodule

// File: rtl/addr_watch_unit.sv
module addr_watch_unit
  import watch_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic [REG_W-1:0]   regWrData,
  output logic [REG_W-1:0]   regRdData,
  input  logic               busValid,
  input  logic [REG_W-1:0]   busAddr,
  input  logic [1:0]         busSize,
  input  logic [1:0]         busKind,
  input  logic               busFirst,
  input  logic               taskSwitch,
  input  logic               singleStep,
  input  logic               emuOverride,
  output logic               trapReq,
  output logic [REG_W-1:0]   statusOut
);
  strobe_t             strb;
  logic [REG_W-1:0]    ctlQ;
  logic [NUM_BP-1:0]   hitVec;
  logic [NUM_BP-1:0]   armVec;

  watch_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .taskSwitch (taskSwitch),
    .singleStep (singleStep),
    .emuOverride(emuOverride),
    .hitVec     (hitVec),
    .armVec     (armVec),
    .strb       (strb),
    .statusQ    (statusOut),
    .trapQ      (trapReq)
  );

  watch_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .statusIn   (statusOut),
    .regRdData  (regRdData),
    .busValid   (busValid),
    .busAddr    (busAddr),
    .busSize    (busSize),
    .busKind    (busKind),
    .busFirst   (busFirst),
    .emuOverride(emuOverride),
    .ctlQ       (ctlQ),
    .hitVec     (hitVec),
    .armVec     (armVec)
  );
endmodule

// File: rtl/watch_chk.sv
module watch_chk (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic [2:0]  regAddr,
  input logic        taskSwitch,
  input logic        singleStep,
  input logic        emuOverride,
  input logic        trapReq,
  input logic [31:0] statusOut,
  input logic [31:0] ctlVal,
  input logic [3:0]  hitVec,
  input logic [3:0]  armVec
);
  p_hit_sets_status_r3: assert property (@(posedge clk) disable iff (!rstN)
    (hitVec != 4'b0) |=> ((statusOut[3:0] & $past(hitVec)) == $past(hitVec)));

  p_trap_has_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> $past(((hitVec & armVec) != 4'b0) || singleStep));

  p_unarmed_no_trap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!singleStep && ((hitVec & armVec) == 4'b0)) |=> !trapReq);

  p_local_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    taskSwitch |=> ((ctlVal & 32'h0000_0155) == 32'h0));

  p_global_kept_r10: assert property (@(posedge clk) disable iff (!rstN)
    (taskSwitch && !(regWrEn && regAddr == 3'd4)) |=>
      ({ctlVal[31:16], ctlVal[9], ctlVal[7], ctlVal[5], ctlVal[3], ctlVal[1]} ==
       $past({ctlVal[31:16], ctlVal[9], ctlVal[7], ctlVal[5], ctlVal[3], ctlVal[1]})));

  p_emu_no_hit_r12: assert property (@(posedge clk) disable iff (!rstN)
    (emuOverride && !(regWrEn && regAddr == 3'd5)) |=>
      ((statusOut[3:0] & ~$past(statusOut[3:0])) == 4'b0));

  p_step_traps_r13: assert property (@(posedge clk) disable iff (!rstN)
    singleStep |=> (trapReq && statusOut[14]));
endmodule

bind addr_watch_unit watch_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regWrEn    (regWrEn),
  .regAddr    (regAddr),
  .taskSwitch (taskSwitch),
  .singleStep (singleStep),
  .emuOverride(emuOverride),
  .trapReq    (trapReq),
  .statusOut  (statusOut),
  .ctlVal     (ctlQ),
  .hitVec     (hitVec),
  .armVec     (armVec)
);

// File: tb/addr_watch_unit_tb.sv
`timescale 1ns/1ps
module addr_watch_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWrData = 32'h0;
  logic [31:0] regRdData;
  logic        busValid = 1'b0;
  logic [31:0] busAddr = 32'h0;
  logic [1:0]  busSize = 2'd0;
  logic [1:0]  busKind = 2'd3;
  logic        busFirst = 1'b0;
  logic        taskSwitch = 1'b0;
  logic        singleStep = 1'b0;
  logic        emuOverride = 1'b0;
  logic        trapReq;
  logic [31:0] statusOut;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  string curReq = "R1";

  logic [31:0] mAddr [4];
  logic [31:0] mCtl = 32'h0;
  logic [31:0] mStat = 32'h0;
  bit          mTrap = 0;

  always #2 clk = ~clk;

  addr_watch_unit u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .busValid(busValid),
    .busAddr(busAddr), .busSize(busSize), .busKind(busKind), .busFirst(busFirst),
    .taskSwitch(taskSwitch), .singleStep(singleStep), .emuOverride(emuOverride),
    .trapReq(trapReq), .statusOut(statusOut)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit mHit(int n);
    int len = int'((mCtl >> (18 + 4*n)) & 32'h3);
    int typ = int'((mCtl >> (16 + 4*n)) & 32'h3);
    longint span, lo, hi, aLo, aHi;
    bit classOk;
    if (!busValid || emuOverride || len == 2) return 0;
    span = (len == 3) ? 4 : (len == 1) ? 2 : 1;
    lo = (longint'(mAddr[n]) / span) * span;
    hi = lo + span - 1;
    classOk = (typ == 0 && busKind == 2'd0 && busFirst && len == 0) ||
              (typ == 1 && busKind == 2'd2) ||
              (typ == 3 && (busKind == 2'd1 || busKind == 2'd2));
    aLo = longint'(busAddr);
    if (busKind == 2'd0 || busSize == 2'd0) aHi = aLo;
    else if (busSize == 2'd1) aHi = aLo + 1;
    else aHi = aLo + 3;
    return classOk && (aLo <= hi) && (aHi >= lo);
  endfunction

  function automatic logic [31:0] mRead(logic [2:0] a);
    if (a < 3'd4) return mAddr[a[1:0]];
    if (a == 3'd4) return mCtl;
    if (a == 3'd5) return mStat;
    return 32'h0;
  endfunction

  task automatic cycle();
    logic [31:0] nAddr [4];
    logic [31:0] nCtl, nStat;
    bit nTrap;
    bit [3:0] h;
    for (int n = 0; n < 4; n++) h[n] = mHit(n);
    nAddr = mAddr;
    if (regWrEn && regAddr < 3'd4) nAddr[regAddr[1:0]] = regWrData;
    nCtl = mCtl;
    if (regWrEn && regAddr == 3'd4) nCtl = regWrData & 32'hFFFF_03FF;
    if (taskSwitch) nCtl = nCtl & ~32'h0000_0155;
    nStat = mStat;
    if (regWrEn && regAddr == 3'd5) nStat = regWrData & 32'h0000_E00F;
    nStat = nStat | {28'h0, h};
    if (emuOverride) nStat[13] = 1'b1;
    if (singleStep)  nStat[14] = 1'b1;
    if (taskSwitch)  nStat[15] = 1'b1;
    nTrap = singleStep;
    for (int n = 0; n < 4; n++)
      if (h[n] && (mCtl[2*n] || mCtl[2*n+1])) nTrap = 1;
    @(posedge clk);
    mAddr = nAddr; mCtl = nCtl; mStat = nStat; mTrap = nTrap;
    #1;
    chk(curReq, statusOut, mStat, "status vs model");
    chk(curReq, {31'h0, trapReq}, {31'h0, mTrap}, "trap vs model");
    chk(curReq, regRdData, mRead(regAddr), "readback vs model");
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    cycle();
    regWrEn = 1'b0;
  endtask

  task automatic acc(logic [31:0] a, logic [1:0] sz, logic [1:0] kind, logic first);
    busValid = 1'b1; busAddr = a; busSize = sz; busKind = kind; busFirst = first;
    cycle();
    busValid = 1'b0; busKind = 2'd3; busFirst = 1'b0;
  endtask

  task automatic expTrap(bit e, string req);
    chk(req, {31'h0, trapReq}, {31'h0, e}, "trap");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < 4; n++) mAddr[n] = 32'h0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1: reset state
    curReq = "R1";
    regAddr = 3'd4; #1;
    chk("R1", statusOut, 32'h0, "status after reset");
    chk("R1", {31'h0, trapReq}, 32'h0, "trap after reset");
    chk("R1", regRdData, 32'h0, "control after reset");
    cycle();

    // R2: register map and writable masks
    curReq = "R2";
    wr(3'd0, 32'h0000_1000);
    regAddr = 3'd0; #1 chk("R2", regRdData, 32'h0000_1000, "watch0 readback");
    wr(3'd4, 32'hFFFF_FFFF);
    chk("R2", regRdData, 32'hFFFF_03FF, "control mask");
    wr(3'd5, 32'hFFFF_FFFF);
    chk("R2", statusOut, 32'h0000_E00F, "status mask");
    wr(3'd5, 32'h0);
    wr(3'd1, 32'h0000_2002);
    wr(3'd2, 32'h0000_3005);
    wr(3'd3, 32'h0000_4000);
    // w0 byte any-data G, w1 word any-data L, w2 dword write G, w3 fetch unarmed
    wr(3'd4, 32'h0D73_0026);

    curReq = "R3";
    acc(32'h1000, 2'd0, 2'd1, 1'b0); expTrap(1, "R3");
    chk("R3", statusOut[3:0], 4'h1, "hit bit0");
    wr(3'd5, 32'h0);
    acc(32'h1001, 2'd0, 2'd1, 1'b0); expTrap(0, "R3");

    curReq = "R4";
    acc(32'h2003, 2'd0, 2'd1, 1'b0); expTrap(1, "R4");
    acc(32'h2001, 2'd2, 2'd2, 1'b0); expTrap(1, "R4");
    acc(32'h2004, 2'd1, 2'd1, 1'b0); expTrap(0, "R4");
    acc(32'h2000, 2'd1, 2'd1, 1'b0); expTrap(0, "R4");
    wr(3'd5, 32'h0);

    curReq = "R5";
    acc(32'h3007, 2'd0, 2'd2, 1'b0); expTrap(1, "R5");
    acc(32'h3008, 2'd2, 2'd2, 1'b0); expTrap(0, "R5");
    acc(32'h3002, 2'd2, 2'd2, 1'b0); expTrap(1, "R5");
    wr(3'd5, 32'h0);

    curReq = "R6";
    acc(32'h3004, 2'd0, 2'd1, 1'b0); expTrap(0, "R6");
    chk("R6", statusOut[3:0], 4'h0, "read on write-only watch");
    acc(32'h1000, 2'd0, 2'd0, 1'b1); expTrap(0, "R6");
    acc(32'h4000, 2'd0, 2'd0, 1'b0);
    chk("R6", statusOut[3:0], 4'h0, "fetch without first-byte");
    acc(32'h4000, 2'd0, 2'd0, 1'b1);
    chk("R6", statusOut[3:0], 4'h8, "first-byte fetch hit");

    curReq = "R8";
    expTrap(0, "R8");
    wr(3'd5, 32'h0);

    curReq = "R7";
    wr(3'd4, 32'h0D7B_0026);
    acc(32'h1000, 2'd0, 2'd1, 1'b0); expTrap(0, "R7");
    wr(3'd4, 32'h0D72_0026);
    acc(32'h1000, 2'd0, 2'd1, 1'b0); expTrap(0, "R7");
    chk("R7", statusOut[3:0], 4'h0, "reserved codes");
    wr(3'd4, 32'h0D73_0026);

    curReq = "R9";
    acc(32'h1000, 2'd0, 2'd1, 1'b0); expTrap(1, "R9");
    acc(32'h1000, 2'd0, 2'd2, 1'b0); expTrap(1, "R9");
    cycle(); expTrap(0, "R9");

    curReq = "R10";
    regAddr = 3'd4;
    taskSwitch = 1'b1; cycle(); taskSwitch = 1'b0;
    chk("R10", regRdData, 32'h0D73_0022, "control after task switch");
    chk("R10", {31'h0, statusOut[15]}, 32'h1, "task bit");
    acc(32'h2003, 2'd0, 2'd1, 1'b0); expTrap(0, "R10");

    curReq = "R11";
    cycle(); cycle();
    chk("R11", statusOut & 32'h0000_8003, 32'h0000_8003, "sticky bits");
    regWrEn = 1'b1; regAddr = 3'd5; regWrData = 32'h0;
    busValid = 1'b1; busAddr = 32'h1000; busSize = 2'd0; busKind = 2'd1;
    cycle();
    regWrEn = 1'b0; busValid = 1'b0; busKind = 2'd3;
    chk("R11", statusOut, 32'h1, "hit with clearing write");
    wr(3'd5, 32'h0);

    curReq = "R12";
    emuOverride = 1'b1;
    acc(32'h1000, 2'd0, 2'd1, 1'b0); expTrap(0, "R12");
    emuOverride = 1'b0;
    chk("R12", statusOut, 32'h0000_2000, "override status");
    wr(3'd5, 32'h0);

    curReq = "R13";
    singleStep = 1'b1; cycle(); singleStep = 1'b0;
    expTrap(1, "R13");
    chk("R13", statusOut, 32'h0000_4000, "step status");
    cycle(); expTrap(0, "R13");

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule